// File: doc/BRIEF.md
# Supervisory Watchdog with Stretched Reset and Flag Outputs

This block guards a host controller against a stalled program. A down-counter is loaded with a configured timeout. It then counts one step on each tick of a selectable time base. That base is either a tick derived from the main clock input or a tick from an internal low-power oscillator. Logic elsewhere on the chip keeps the count alive by pulsing a clear strobe. An internal reset also restarts the count. If neither arrives before the count runs out, the block raises two outputs. The first is a reset request for the reset generator. The second is a flag that the logic array can route to the host as an interrupt.

Each output is stretched by its own pulse generator to a configured number of ticks of the selected time base. While a pulse is running, the counter is held. When the last pulse finishes, the counter is reloaded, so the next watchdog period starts from a clean state. A power-down indication is accepted but leaves counting and both outputs unchanged. Clearing the enable holds the counter at its reload value and silences both outputs.

All logic runs on one system clock `clk`. Both time bases arrive as one-cycle tick strobes that are synchronous to `clk`. Timeout and width values are sampled only when the counter reloads.

Top module: `wdg_supervisor`

## Requirements
- R1: After `rst_n` is released, both `rst_req` and `wd_flag` are low, and the counter loads `timeout_cfg` on the first clock edge.
- R2: With a reload value T, both outputs go high on the clock edge that samples the T-th selected tick after the reload. A T of 0 behaves as 1.
- R3: `rst_req` stays high for exactly Wr selected ticks, where Wr is `rst_width_cfg` latched at the last reload. A Wr of 0 behaves as 1.
- R4: `wd_flag` rises together with `rst_req` and stays high for exactly Wf selected ticks, where Wf comes from `flag_width_cfg`. Wf is independent of Wr, and a Wf of 0 behaves as 1.
- R5: A `clr` pulse while no output is active reloads the counter, so a full T ticks must pass before the next expiry.
- R6: An `int_rst` pulse reloads the counter in the same way as `clr`.
- R7: A `clr` pulse while either output is active is ignored and does not shorten either pulse.
- R8: When the last active pulse ends, the counter reloads, and the next expiry comes exactly T ticks later.
- R9: While `en` is low, both outputs are low from the next clock edge, any running pulse is ended, ticks are ignored, and the counter is held at its reload value.
- R10: `tick_sel` = 0 selects `ext_tick` and `tick_sel` = 1 selects `osc_tick`. Ticks on the unselected input have no effect.
- R11: `pwr_down` has no effect on counting or on either output.
- R12: A change of `timeout_cfg` without a reload does not change the period that is already counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Watchdog enable |
| clr | input | 1 | Keep-alive clear strobe from logic |
| int_rst | input | 1 | Internal reset; reloads the counter |
| pwr_down | input | 1 | Power-down indication; no effect on behaviour |
| tick_sel | input | 1 | Time base select: 0 = ext_tick, 1 = osc_tick |
| ext_tick | input | 1 | Tick strobe derived from the main clock input |
| osc_tick | input | 1 | Tick strobe from the internal low-power oscillator |
| timeout_cfg | input | CNT_W | Timeout in ticks, sampled on reload |
| rst_width_cfg | input | PW | Reset pulse width in ticks, sampled on reload |
| flag_width_cfg | input | PW | Flag pulse width in ticks, sampled on reload |
| rst_req | output | 1 | Stretched reset request |
| wd_flag | output | 1 | Stretched interrupt-capable flag |

## Verification
The hardest situation to reach from the ports is the handover at the end of a pulse. This is the moment when the longer of the two stretched outputs finishes and the counter silently reloads. It is visible only through when the next expiry arrives. The stimulus sweeps every combination of small timeout, reset width and flag width values, including zero. In each combination it lets the watchdog expire twice in a row without a clear, so the second period checks that the reload was clean. Directed sequences then place clear strobes, an internal reset, a disable and ticks on the unselected source at chosen tick counts within a period or a pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_OSC = 1'b1
  } wdg_src_e;

  localparam int unsigned NUM_OUTS = 2;
  localparam int unsigned OUT_RST  = 0;
  localparam int unsigned OUT_FLAG = 1;

endpackage

// File: rtl/wdg_tick_mux.sv
module wdg_tick_mux
  import wdg_pkg::*;
(
  input  logic tick_sel,
  input  logic ext_tick,
  input  logic osc_tick,
  output logic tick
);

  wdg_src_e src;

  always_comb begin
    src  = wdg_src_e'(tick_sel);
    tick = (src == SRC_OSC) ? osc_tick : ext_tick;
  end

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          hold,
  input  logic          tick,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  localparam logic [CW-1:0] ONE = CW'(1);

  // A zero timeout would never expire; treat it as the shortest period.
  function automatic logic [CW-1:0] floor_one(input logic [CW-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step   = tick && !hold && !load;
  assign expire = step && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ONE;
    end else if (load) begin
      cnt_q <= floor_one(load_val);
    end else if (step && (cnt_q != ONE)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

endmodule

// File: rtl/wdg_stretch.sv
module wdg_stretch #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          start,
  input  logic          tick,
  input  logic [PW-1:0] width,
  output logic          active,
  output logic          last
);

  localparam logic [PW-1:0] ONE = PW'(1);

  function automatic logic [PW-1:0] floor_one(input logic [PW-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [PW-1:0] rem_q;

  assign last = active && tick && (rem_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rem_q  <= ONE;
    end else if (kill) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      rem_q  <= floor_one(width);
    end else if (active && tick) begin
      if (rem_q == ONE) begin
        active <= 1'b0;
      end
      rem_q <= rem_q - ONE;
    end
  end

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             int_rst,
  input  logic             pwr_down,
  input  logic             tick_sel,
  input  logic             ext_tick,
  input  logic             osc_tick,
  input  logic [CNT_W-1:0] timeout_cfg,
  input  logic [PW-1:0]    rst_width_cfg,
  input  logic [PW-1:0]    flag_width_cfg,
  output logic             rst_req,
  output logic             wd_flag
);

  // Named internal events, observed by the bound checker.
  logic tick_w;
  logic expire_w;
  logic load_w;
  logic hold_w;
  logic all_end_w;

  logic                         started_q;
  logic [NUM_OUTS-1:0][PW-1:0]  width_q;
  logic [NUM_OUTS-1:0][PW-1:0]  width_cfg;
  logic [NUM_OUTS-1:0]          act;
  logic [NUM_OUTS-1:0]          last;

  // Power-down leaves the time base and counting untouched.
  logic unused_pwr_down;
  assign unused_pwr_down = pwr_down;

  assign width_cfg[OUT_RST]  = rst_width_cfg;
  assign width_cfg[OUT_FLAG] = flag_width_cfg;

  wdg_tick_mux u_tick (
    .tick_sel (tick_sel),
    .ext_tick (ext_tick),
    .osc_tick (osc_tick),
    .tick     (tick_w)
  );

  assign hold_w = |act;

  always_comb begin
    all_end_w = hold_w;
    for (int i = 0; i < NUM_OUTS; i++) begin
      if (act[i] && !last[i]) all_end_w = 1'b0;
    end
  end

  assign load_w = !started_q || !en || int_rst || (clr && !hold_w) || all_end_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
    end else if (load_w) begin
      width_q <= width_cfg;
    end
  end

  wdg_countdown #(.CW(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_w),
    .hold     (hold_w),
    .tick     (tick_w),
    .load_val (timeout_cfg),
    .expire   (expire_w)
  );

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_out
    wdg_stretch #(.PW(PW)) u_stretch (
      .clk    (clk),
      .rst_n  (rst_n),
      .kill   (!en),
      .start  (expire_w),
      .tick   (tick_w),
      .width  (width_q[g]),
      .active (act[g]),
      .last   (last[g])
    );
  end

  assign rst_req = act[OUT_RST];
  assign wd_flag = act[OUT_FLAG];

endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic clr,
  input logic rst_req,
  input logic wd_flag,
  input logic tick_w,
  input logic expire_w
);

  // R2
  rise_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(expire_w));

  // R4
  outputs_start_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $rose(wd_flag));

  // R3
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && en && !tick_w) |=> rst_req);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rst_req && !wd_flag));

  // R5
  clear_defers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && en && !rst_req && !wd_flag) |=> (!rst_req && !wd_flag));

endmodule

bind wdg_supervisor wdg_supervisor_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .clr      (clr),
  .rst_req  (rst_req),
  .wd_flag  (wd_flag),
  .tick_w   (tick_w),
  .expire_w (expire_w)
);

// File: tb/test_wdg_supervisor.sv
module test_wdg_supervisor;

  localparam int CNT_W = 16;
  localparam int PW    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b1;
  logic             clr = 1'b0;
  logic             int_rst = 1'b0;
  logic             pwr_down = 1'b0;
  logic             tick_sel = 1'b0;
  logic             ext_tick = 1'b0;
  logic             osc_tick = 1'b0;
  logic [CNT_W-1:0] timeout_cfg = 16'd3;
  logic [PW-1:0]    rst_width_cfg = 8'd1;
  logic [PW-1:0]    flag_width_cfg = 8'd1;
  logic             rst_req;
  logic             wd_flag;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  use_osc  = 1'b0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  wdg_supervisor #(.CNT_W(CNT_W), .PW(PW)) i_wdg_supervisor (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .clr            (clr),
    .int_rst        (int_rst),
    .pwr_down       (pwr_down),
    .tick_sel       (tick_sel),
    .ext_tick       (ext_tick),
    .osc_tick       (osc_tick),
    .timeout_cfg    (timeout_cfg),
    .rst_width_cfg  (rst_width_cfg),
    .flag_width_cfg (flag_width_cfg),
    .rst_req        (rst_req),
    .wd_flag        (wd_flag)
  );

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_both(input string req, input logic er, input logic ef);
    check({req, " rst_req"}, rst_req, er);
    check({req, " wd_flag"}, wd_flag, ef);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (use_osc) osc_tick = 1'b1;
      else         ext_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
      ext_tick = 1'b0;
    end
  endtask

  task automatic wrong_tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (use_osc) ext_tick = 1'b1;
      else         osc_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
      ext_tick = 1'b0;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic pulse_int_rst();
    @(negedge clk); int_rst = 1'b1;
    @(negedge clk); int_rst = 1'b0;
  endtask

  task automatic set_cfg(input int t, input int wr, input int wf);
    @(negedge clk);
    timeout_cfg    = CNT_W'(t);
    rst_width_cfg  = PW'(wr);
    flag_width_cfg = PW'(wf);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected completion");
      summary();
    end
  end

  initial begin
    int te, wre, wfe, wmax;

    // R1: reset state
    repeat (3) @(negedge clk);
    check_both("R1 during reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_both("R1 after reset", 1'b0, 1'b0);
    // Counter was loaded with 3 on the first edge: expiry after three ticks.
    tick_n(2);
    check_both("R1 first load pending", 1'b0, 1'b0);
    tick_n(1);
    check_both("R1 first load expiry", 1'b1, 1'b1);
    tick_n(1);
    check_both("R1 drained", 1'b0, 1'b0);

    // R2 R3 R4 R8: sweep timeout and both widths, including zero.
    for (int t = 0; t <= 4; t++) begin
      for (int wr = 0; wr <= 3; wr++) begin
        for (int wf = 0; wf <= 3; wf++) begin
          te   = at_least_one(t);
          wre  = at_least_one(wr);
          wfe  = at_least_one(wf);
          wmax = (wre > wfe) ? wre : wfe;
          set_cfg(t, wr, wf);
          pulse_clr();
          tick_n(te - 1);
          check_both("R2 before expiry", 1'b0, 1'b0);
          tick_n(1);
          check_both("R2 at expiry", 1'b1, 1'b1);
          for (int k = 1; k <= wmax; k++) begin
            tick_n(1);
            check("R3 reset width", rst_req, (k < wre));
            check("R4 flag width", wd_flag, (k < wfe));
          end
          tick_n(te - 1);
          check_both("R8 reloaded period", 1'b0, 1'b0);
          tick_n(1);
          check_both("R8 second expiry", 1'b1, 1'b1);
          tick_n(wmax);
          check_both("R8 second drain", 1'b0, 1'b0);
        end
      end
    end

    // R5: clear before expiry restarts the full period.
    set_cfg(4, 2, 2);
    pulse_clr();
    tick_n(3);
    pulse_clr();
    tick_n(3);
    check_both("R5 clear restarts", 1'b0, 1'b0);
    tick_n(1);
    check_both("R5 expiry after clear", 1'b1, 1'b1);
    tick_n(2);
    check_both("R5 drained", 1'b0, 1'b0);

    // R6: internal reset reloads the counter.
    set_cfg(3, 1, 1);
    pulse_clr();
    tick_n(2);
    pulse_int_rst();
    tick_n(2);
    check_both("R6 int_rst reload", 1'b0, 1'b0);
    tick_n(1);
    check_both("R6 expiry after int_rst", 1'b1, 1'b1);
    tick_n(1);
    check_both("R6 drained", 1'b0, 1'b0);

    // R7: clear during an active pulse does not shorten it.
    set_cfg(2, 3, 3);
    pulse_clr();
    tick_n(2);
    check_both("R7 pulse start", 1'b1, 1'b1);
    pulse_clr();
    check_both("R7 after clr", 1'b1, 1'b1);
    tick_n(1);
    pulse_clr();
    tick_n(1);
    check_both("R7 still active", 1'b1, 1'b1);
    tick_n(1);
    check_both("R7 full width end", 1'b0, 1'b0);

    // R12: timeout change without reload keeps the running period.
    set_cfg(3, 1, 1);
    pulse_clr();
    @(negedge clk); timeout_cfg = 16'd6;
    tick_n(2);
    check_both("R12 old period pending", 1'b0, 1'b0);
    tick_n(1);
    check_both("R12 old period expiry", 1'b1, 1'b1);
    tick_n(1);
    check_both("R12 drained", 1'b0, 1'b0);

    // R9: disable ends a pulse, ignores ticks, holds the reload value.
    set_cfg(3, 3, 3);
    pulse_clr();
    tick_n(3);
    check_both("R9 pulse before disable", 1'b1, 1'b1);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check_both("R9 disable ends pulse", 1'b0, 1'b0);
    tick_n(10);
    check_both("R9 ticks ignored", 1'b0, 1'b0);
    @(negedge clk); en = 1'b1;
    tick_n(2);
    check_both("R9 held at reload", 1'b0, 1'b0);
    tick_n(1);
    check_both("R9 expiry after enable", 1'b1, 1'b1);
    tick_n(3);
    check_both("R9 drained", 1'b0, 1'b0);

    // R10: oscillator source selected; main-clock ticks ignored.
    set_cfg(3, 1, 1);
    @(negedge clk); tick_sel = 1'b1; use_osc = 1'b1;
    pulse_clr();
    wrong_tick_n(10);
    check_both("R10 unselected ignored", 1'b0, 1'b0);
    tick_n(2);
    check_both("R10 osc pending", 1'b0, 1'b0);
    tick_n(1);
    check_both("R10 osc expiry", 1'b1, 1'b1);
    wrong_tick_n(3);
    check_both("R10 unselected keeps pulse", 1'b1, 1'b1);
    tick_n(1);
    check_both("R10 drained", 1'b0, 1'b0);
    @(negedge clk); tick_sel = 1'b0; use_osc = 1'b0;

    // R11: power-down changes nothing.
    set_cfg(2, 2, 1);
    @(negedge clk); pwr_down = 1'b1;
    pulse_clr();
    tick_n(1);
    check_both("R11 pending", 1'b0, 1'b0);
    tick_n(1);
    check_both("R11 expiry", 1'b1, 1'b1);
    tick_n(1);
    check_both("R11 widths", 1'b1, 1'b0);
    tick_n(1);
    check_both("R11 drained", 1'b0, 1'b0);

    finished = 1'b1;
    summary();
  end

endmodule